// File: doc/BRIEF.md
# Programmable asynchronous serial receiver

This block recovers characters from an asynchronous serial line and queues them for a host. The line is re-timed into the clock domain, then sampled with a 16x oversampling tick enable supplied from outside. The frame layout is chosen at run time: character length, parity mode and number of stop bits. The configuration is captured when each start bit is found, so a change while a frame is in flight does not affect that frame.

Every received character is checked for parity, framing and break. It is written into a receive FIFO together with its own error flags, so the flags reach the host with the character they describe. A character that finds the FIFO full is dropped and signalled on a one-cycle overrun pulse. The FIFO occupancy is always visible on a fill-level output.

The host side is a valid/ready stream. `out_valid` stays high while the FIFO holds a character. The head character and its flags stay stable until the cycle in which `out_valid` and `out_ready` are both high, which removes it. Holding `out_ready` low applies back-pressure, and characters accumulate until the FIFO fills.

Top module: `async_rx`

## Requirements
- R1: `cfg_len` selects the character length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). Bits arrive least significant first, and `out_data` bits above the selected length read zero.
- R2: After a falling edge is seen on a tick, the line is re-sampled on the 8th following tick (mid start bit). Every later bit is sampled 16 ticks after the previous sample, and the state moves only on ticks.
- R3: If the line is high at the mid-start sample, the edge is a false start. The receiver returns to idle and stores nothing.
- R4: `cfg_parity` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = parity bit always 1, 4 = parity bit always 0, and 5 to 7 behave as none. A received parity bit that disagrees with the mode sets that character's parity-error flag.
- R5: `cfg_two_stop` = 1 adds a second stop bit, which is half a bit long for 5-bit characters and a full bit long otherwise. A stop bit sampled low sets the character's framing-error flag.
- R6: If every sampled bit of a frame, including all stop bits, is low, a break is recorded. One character of value 0 is stored with the break and framing flags set, and no new start bit is accepted until the line has been seen high on a tick.
- R7: A character completed while the FIFO holds DEPTH entries is dropped, even if a pop happens in the same cycle. `overrun` pulses for one cycle and the stored characters are kept.
- R8: Characters leave in arrival order. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the flags hold their values.
- R9: `fill_level` gives the number of stored characters, from 0 to DEPTH (default 16). A pop without a push lowers it by one in the next cycle.
- R10: The parity, framing and break flags are output together with the character they were found on, when that character reaches the head of the FIFO.
- R11: After reset, `out_valid`, `overrun` and `fill_level` are 0 and the line is treated as idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length select |
| cfg_parity | input | 3 | Parity mode select |
| cfg_two_stop | input | 1 | Second stop bit enable |
| out_valid | output | 1 | Head character available |
| out_ready | input | 1 | Host accepts head character |
| out_data | output | 8 | Head character, right-aligned |
| out_par_err | output | 1 | Parity error flag of head character |
| out_frm_err | output | 1 | Framing error flag of head character |
| out_brk | output | 1 | Break flag of head character |
| fill_level | output | $clog2(DEPTH+1) | Number of stored characters |
| overrun | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The properties check on every cycle that the receiver state moves only on ticks, that a false start never leads to a store, and that a break character is zero and carries its framing flag. They also check that the unused upper data bits are clear, that the head of the FIFO holds under back-pressure, that the fill level stays bounded and drops on a lone pop, and that a drop into a full FIFO leaves it full. Correct bit values, parity arithmetic for each mode, the half-length stop bit, the return to idle after a break, and the survival of the stored flags through a full FIFO and an overrun can only be shown by the bench's serial scenarios checked against its scoreboard.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_ONE   = 3'd3,
    PAR_ZERO  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2,
    S_HOLD
  } rx_state_e;

  // Stored entry: flags travel with the character
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_char_t;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b1;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '1;
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       cfg_stop2,
  output logic       push_o,
  output rx_char_t   char_o
);

  localparam int CW    = $clog2(OVS);
  localparam int HALF  = OVS / 2 - 1;
  localparam int FULL  = OVS - 1;
  localparam int SHORT = (OVS * 3) / 4 - 1;

  rx_state_e  st;
  logic [CW-1:0] cnt;
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic       par_bit, any_hi, frm_q;
  logic [1:0] len_q;
  par_mode_e  par_q;
  logic       stop2_q;
  logic       push_q;
  rx_char_t   char_q;

  logic       mid_hit, full_hit, stop2_hit, last_data, par_on;
  logic [7:0] data_al;
  logic       ones, par_err, seen_hi, fin_frm, fin_now;

  always_comb begin
    mid_hit   = (cnt == CW'(HALF));
    full_hit  = (cnt == CW'(FULL));
    stop2_hit = (len_q == 2'd0) ? (cnt == CW'(SHORT)) : full_hit;
    last_data = (bit_idx == (3'd4 + {1'b0, len_q}));
    par_on    = (par_q == PAR_EVEN) || (par_q == PAR_ODD) ||
                (par_q == PAR_ONE)  || (par_q == PAR_ZERO);
    data_al   = shreg >> {1'b0, (2'd3 - len_q)};
    ones      = ^data_al;
    case (par_q)
      PAR_EVEN: par_err = (par_bit != ones);
      PAR_ODD:  par_err = (par_bit == ones);
      PAR_ONE:  par_err = !par_bit;
      PAR_ZERO: par_err = par_bit;
      default:  par_err = 1'b0;
    endcase
    seen_hi = any_hi | rx;
    fin_frm = (st == S_STOP2) ? (frm_q | ~rx) : ~rx;
    fin_now = tick && (((st == S_STOP1) && full_hit && !stop2_q) ||
                       ((st == S_STOP2) && stop2_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      any_hi  <= 1'b0;
      frm_q   <= 1'b0;
      len_q   <= 2'd3;
      par_q   <= PAR_NONE;
      stop2_q <= 1'b0;
      push_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      push_q <= 1'b0;
      if (fin_now) begin
        push_q <= 1'b1;
        cnt    <= '0;
        if (!seen_hi) begin
          char_q <= {1'b1, 1'b1, 1'b0, 8'h00};
          st     <= S_HOLD;
        end else begin
          char_q <= {1'b0, fin_frm, par_err, data_al};
          st     <= S_IDLE;
        end
      end else if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx) begin
              st      <= S_START;
              cnt     <= '0;
              len_q   <= cfg_len;
              par_q   <= par_mode_e'(cfg_par);
              stop2_q <= cfg_stop2;
              bit_idx <= '0;
              shreg   <= '0;
              any_hi  <= 1'b0;
              frm_q   <= 1'b0;
              par_bit <= 1'b0;
            end
          end
          S_START: begin
            if (mid_hit) begin
              cnt <= '0;
              st  <= rx ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (full_hit) begin
              cnt    <= '0;
              shreg  <= {rx, shreg[7:1]};
              any_hi <= seen_hi;
              if (last_data) st <= par_on ? S_PAR : S_STOP1;
              else           bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (full_hit) begin
              cnt     <= '0;
              par_bit <= rx;
              any_hi  <= seen_hi;
              st      <= S_STOP1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP1: begin
            if (full_hit) begin
              cnt    <= '0;
              frm_q  <= ~rx;
              any_hi <= seen_hi;
              st     <= S_STOP2;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP2: cnt <= cnt + 1'b1;
          S_HOLD:  if (rx) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign push_o = push_q;
  assign char_o = char_q;

  // R2: receiver state advances only on oversampling ticks
  a_r2_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> $past(tick));

  // R3: a high mid-start sample returns to idle with no store
  a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == S_START && mid_hit && rx) |=> (st == S_IDLE && !push_o));

  // R6: break entry is zero, framed, and parks the receiver
  a_r6_break_char: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && char_o.brk) |-> (char_o.data == 8'h00 && char_o.frm && st == S_HOLD));

  // R1: bits above the captured length are clear
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && !char_o.brk) |-> ((char_o.data >> (4'd5 + {2'b00, len_q})) == 8'h00));

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       valid,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       ovr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, push_ok, pop_ok, ovr_q;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= push && full;
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign valid = (count != '0);
  assign fill  = count;
  assign ovr   = ovr_q;

  // R9: occupancy never exceeds the depth
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: lone pop lowers the fill level by one
  a_r9_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid && !push) |=> (count == $past(count) - 1'b1));

  // R8: head holds under back-pressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop) |=> (valid && $stable(dout)));

  // R7: dropped character leaves the FIFO full and raises the pulse
  a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && ovr));

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       os_tick,
  input  logic                       rxd,
  input  logic [1:0]                 cfg_len,
  input  logic [2:0]                 cfg_parity,
  input  logic                       cfg_two_stop,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       out_par_err,
  output logic                       out_frm_err,
  output logic                       out_brk,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       overrun
);

  localparam int EW = $bits(rx_char_t);

  logic     rx_s;
  logic     push;
  rx_char_t char_in;
  rx_char_t head;
  logic [EW-1:0] head_bits;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (rx_s)
  );

  async_rx_frame #(.OVS(OVS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rx        (rx_s),
    .cfg_len   (cfg_len),
    .cfg_par   (cfg_parity),
    .cfg_stop2 (cfg_two_stop),
    .push_o    (push),
    .char_o    (char_in)
  );

  async_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (char_in),
    .pop   (out_ready),
    .dout  (head_bits),
    .valid (out_valid),
    .fill  (fill_level),
    .ovr   (overrun)
  );

  assign head        = rx_char_t'(head_bits);
  assign out_data    = head.data;
  assign out_par_err = head.par;
  assign out_frm_err = head.frm;
  assign out_brk     = head.brk;

endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVS        = 16;
  localparam int BIT_CLK    = TICK_DIV * OVS;
  localparam int DEPTH      = 16;
  localparam int FW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          os_tick = 1'b0;
  logic          rxd = 1'b1;
  logic [1:0]    cfg_len = 2'd3;
  logic [2:0]    cfg_parity = 3'd0;
  logic          cfg_two_stop = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;
  logic          out_par_err, out_frm_err, out_brk;
  logic [FW-1:0] fill_level;
  logic          overrun;

  int n_chk = 0;
  int n_fail = 0;
  int n_ovr = 0;
  logic [10:0] exp_q [$];
  string       tag_q [$];
  logic [10:0] mon_got, mon_exp;
  string       mon_tag;

  async_rx #(.DEPTH(DEPTH), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .out_brk(out_brk),
    .fill_level(fill_level), .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 os_tick = 1'b1;
      @(posedge clk);
      #1 os_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Scoreboard monitor: compares each accepted character against the queue
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      mon_got = {out_brk, out_frm_err, out_par_err, out_data};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected character", int'(mon_got), 0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(mon_got == mon_exp, mon_tag, "character", int'(mon_got), int'(mon_exp));
      end
    end
    if (rst_n && overrun) n_ovr++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    report();
  end

  task automatic line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(posedge clk);
    #1;
  endtask

  // Driver: builds one frame on the line and queues its expected entry
  task automatic send(input logic [7:0] d, input int nb, input logic [2:0] pm,
                      input bit s2, input bit bad_par, input logic [1:0] slow,
                      input bit keep, input string tag);
    logic [7:0] dm;
    logic pb, frm, perr, par_used;
    dm       = d & 8'((1 << nb) - 1);
    par_used = (pm >= 3'd1) && (pm <= 3'd4);
    case (pm)
      3'd1:    pb = ^dm;
      3'd2:    pb = ~(^dm);
      3'd3:    pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (bad_par) pb = ~pb;
    frm  = slow[0] | (s2 & slow[1]);
    perr = bad_par && par_used;
    if (keep) begin
      exp_q.push_back({1'b0, frm, perr, dm});
      tag_q.push_back(tag);
    end
    cfg_len      = 2'(nb - 5);
    cfg_parity   = pm;
    cfg_two_stop = s2;
    line(1'b0, BIT_CLK);
    for (int i = 0; i < nb; i++) line(dm[i], BIT_CLK);
    if (par_used) line(pb, BIT_CLK);
    line(~slow[0], BIT_CLK);
    if (s2) line(~slow[1], (nb == 5) ? BIT_CLK / 2 : BIT_CLK);
    line(1'b1, BIT_CLK);
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    chk(fill_level == '0, "R11", "fill after reset", int'(fill_level), 0);
    chk(overrun == 1'b0, "R11", "overrun after reset", int'(overrun), 0);
    line(1'b1, BIT_CLK);

    // R1 / R2: lengths, LSB first, centre sampling
    send(8'hA5, 8, 3'd0, 0, 0, 2'b00, 1, "R1");
    send(8'hFF, 5, 3'd0, 0, 0, 2'b00, 1, "R1");
    send(8'hC3, 6, 3'd0, 0, 0, 2'b00, 1, "R1");
    send(8'h6B, 7, 3'd0, 0, 0, 2'b00, 1, "R2");

    // R4: each parity mode, good and bad
    send(8'h3C, 7, 3'd1, 0, 0, 2'b00, 1, "R4");
    send(8'h1B, 6, 3'd2, 0, 0, 2'b00, 1, "R4");
    send(8'h16, 5, 3'd3, 0, 0, 2'b00, 1, "R4");
    send(8'hF0, 8, 3'd4, 0, 0, 2'b00, 1, "R4");
    send(8'h55, 8, 3'd1, 0, 1, 2'b00, 1, "R4");
    send(8'h33, 8, 3'd2, 0, 1, 2'b00, 1, "R4");
    send(8'h0F, 7, 3'd3, 0, 1, 2'b00, 1, "R4");
    send(8'h41, 8, 3'd4, 0, 1, 2'b00, 1, "R4");

    // R5: stop bit counts and framing errors
    send(8'h5A, 8, 3'd0, 1, 0, 2'b00, 1, "R5");
    send(8'h0D, 5, 3'd1, 1, 0, 2'b00, 1, "R5");
    send(8'h77, 8, 3'd0, 0, 0, 2'b01, 1, "R5");
    send(8'h2E, 8, 3'd2, 1, 0, 2'b10, 1, "R5");
    send(8'h13, 5, 3'd0, 1, 0, 2'b10, 1, "R5");
    line(1'b1, BIT_CLK);
    chk(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);

    // R3: false starts (3 ticks and 6 ticks low)
    cfg_len = 2'd3; cfg_parity = 3'd0; cfg_two_stop = 1'b0;
    line(1'b0, 3 * TICK_DIV);
    line(1'b1, 2 * BIT_CLK);
    line(1'b0, 6 * TICK_DIV);
    line(1'b1, 2 * BIT_CLK);
    chk(fill_level == '0, "R3", "fill after false start", int'(fill_level), 0);
    chk(out_valid == 1'b0, "R3", "valid after false start", int'(out_valid), 0);
    send(8'h3E, 8, 3'd0, 0, 0, 2'b00, 1, "R3");

    // R6: break, one stored zero, re-arm only after line high
    exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    tag_q.push_back("R6");
    line(1'b0, 14 * BIT_CLK);
    chk(exp_q.size() == 0, "R6", "break stored once while low", exp_q.size(), 0);
    line(1'b1, 2 * BIT_CLK);
    chk(fill_level == '0, "R6", "no extra entry after break", int'(fill_level), 0);
    send(8'h81, 8, 3'd0, 0, 0, 2'b00, 1, "R6");

    // R7 / R8 / R9 / R10: fill under back-pressure, then overrun
    out_ready = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == 3)      send(8'(8'h20 + k), 8, 3'd1, 0, 1, 2'b00, 1, "R10");
      else if (k == 7) send(8'(8'h20 + k), 8, 3'd0, 0, 0, 2'b01, 1, "R10");
      else             send(8'(8'h20 + k), 8, 3'd0, 0, 0, 2'b00, 1, "R8");
      if (k == 4) chk(fill_level == FW'(5), "R9", "fill after 5", int'(fill_level), 5);
    end
    chk(fill_level == FW'(DEPTH), "R9", "fill when full", int'(fill_level), DEPTH);
    chk(out_valid && out_data == 8'h20, "R8", "head held", int'(out_data), 'h20);
    begin
      int ovr0;
      ovr0 = n_ovr;
      send(8'h99, 8, 3'd0, 0, 0, 2'b00, 0, "R7");
      chk(n_ovr == ovr0 + 1, "R7", "overrun pulses", n_ovr - ovr0, 1);
    end
    chk(fill_level == FW'(DEPTH), "R7", "fill kept", int'(fill_level), DEPTH);
    chk(out_data == 8'h20, "R7", "head kept", int'(out_data), 'h20);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk(fill_level == FW'(DEPTH - 1), "R9", "fill after one pop", int'(fill_level), DEPTH - 1);
    repeat (DEPTH + 4) @(posedge clk);
    #1;
    chk(fill_level == '0, "R9", "fill after drain", int'(fill_level), 0);
    chk(exp_q.size() == 0, "R8", "all delivered in order", exp_q.size(), 0);
    report();
  end

endmodule